// File: doc/BRIEF.md
# Byte-Interleaved Bus Time-Slot Extractor

This block sits on the receive side of one framer. The framer is attached to a shared serial system bus that runs at 8.192 Mb/s. Four 2.048 Mb/s streams travel on that bus, interleaved one byte at a time. A common frame pulse marks the start of every 125 µs frame, and each frame holds 128 byte positions. A 7-bit slot offset tells the block where its own bytes begin. It keeps every fourth byte position, counting from that offset, and recovers its 32 time slots. Each one is delivered as a parallel byte with its slot number and a one-cycle strobe.

A second serial line carries signaling bits that are aligned to the same time slots. The block deserializes that line in step with the data. It presents the signaling byte beside each data byte. When common-channel signaling is off and the signaling source selects the bus line, the signaling byte takes the place of time slot 16.

The bus clock is the block clock. It runs either at the bit rate or at twice the bit rate. In double-rate mode a phase select picks which of the two cycles of a bit samples data and signaling. The frame pulse is looked at only on the first cycle of a bit. The pulse polarity can be inverted. A pulse that arrives away from the frame boundary moves the counters to that pulse and raises an alignment-error strobe.

Top module: `mbx_extract`

## Requirements
- R1: A bus byte at frame position k (0 to 127, where position 0 starts with the frame pulse) is output only when (k − offset) mod 4 equals 0.
- R2: The output slot number is ((k − offset) mod 128) / 4, so offsets near the top of the range wrap into low slot numbers.
- R3: The first bit of a byte on the bus lands in the MSB of the output byte.
- R4: With the double-rate bit at 0, every clock cycle carries one bus bit.
- R5: With the double-rate bit at 1, each bit lasts two cycles. Data and signaling are sampled on the first cycle when the phase select is 0, and on the second cycle when it is 1.
- R6: In double-rate mode, once the block is aligned, a frame pulse seen only on the second cycle of a bit is ignored. It causes no error and does not disturb the counters.
- R7: With the invert bit at 0 the frame pulse is active high, and with it at 1 the pulse is active low.
- R8: When the common-channel bit is 0 and the signaling-source bit is 0, the data output for slot 16 is the signaling byte.
- R9: The signaling byte of each slot is always output. When the common-channel bit or the signaling-source bit is 1, slot 16 carries the bus data unchanged.
- R10: A frame pulse seen at a position other than frame position 0 moves the counters to that pulse as the new position 0 and raises align_err for one cycle.
- R11: Before the first frame pulse after reset, no byte is output. A frame pulse at the expected wrap raises no error.
- R12: After reset, ts_valid and align_err are 0. ts_valid is a single-cycle strobe for each delivered byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, single domain |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_double_rate | input | 1 | 1: two clock cycles per bus bit |
| cfg_phase_sel | input | 1 | Sampling cycle within a bit in double-rate mode |
| cfg_fp_invert | input | 1 | 1: frame pulse active low |
| cfg_slot_offset | input | 7 | Byte position of this framer's first byte |
| cfg_ccs_en | input | 1 | Common-channel signaling enabled |
| cfg_sig_src | input | 1 | 1: slot 16 not taken from the signaling line |
| bus_fp | input | 1 | Common frame pulse |
| bus_data | input | 1 | Multiplexed serial data |
| bus_sig | input | 1 | Multiplexed serial signaling |
| ts_valid | output | 1 | One-cycle strobe, byte delivered |
| ts_num | output | 5 | Time-slot number of the delivered byte |
| ts_data | output | 8 | Delivered data byte |
| ts_sig | output | 8 | Signaling byte for that slot |
| align_err | output | 1 | Frame pulse seen out of position |

## Verification
The hardest behaviour to reach from the ports is the choice of sampling cycle in double-rate mode. If the same bit is held for both cycles, a wrong phase would still give the right bytes. The stimulus therefore drives the complement of each bit on the cycle that is not selected, so any wrong phase corrupts every byte. It also places a frame pulse only on the second cycle of a bit in the middle of a frame. Pulses are placed mid-frame in both clock modes, so the error strobe and the shift in slot numbers after the realignment both show up.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
   localparam int SIG_SLOT = 16;

   typedef struct packed {
      logic dbl;
      logic phase_sel;
      logic fp_inv;
      logic ccs_en;
      logic sig_src;
   } mbx_cfg_t;
endpackage

// File: rtl/mbx_timing.sv
module mbx_timing
   import mbx_pkg::*;
#(
   parameter int TOTAL_BITS = 1024,
   parameter int POS_W      = 10,
   parameter bit DBL_EN     = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  mbx_cfg_t         cfg,
   input  logic             fp_in,
   output logic             samp_en,
   output logic [POS_W-1:0] bit_pos,
   output logic             locked_o,
   output logic             align_err
);
   logic             dbl_on;
   logic             locked_q, phase_q, err_q;
   logic [POS_W-1:0] pos_q, cur_pos, nxt_pos;
   logic             fp_act, fp_look, fp_take, cur_phase, adv;

   generate
      if (DBL_EN) begin : g_dbl
         assign dbl_on = cfg.dbl;
      end else begin : g_single
         assign dbl_on = 1'b0;
      end
   endgenerate

   always_comb begin
      fp_act    = fp_in ^ cfg.fp_inv;
      fp_look   = !locked_q || !dbl_on || !phase_q;
      fp_take   = fp_act && fp_look;
      cur_pos   = fp_take ? '0 : pos_q;
      cur_phase = dbl_on && !fp_take && phase_q;
      adv       = !dbl_on || cur_phase;
      nxt_pos   = (cur_pos == POS_W'(TOTAL_BITS - 1)) ? '0 : cur_pos + POS_W'(1);
      samp_en   = (locked_q || fp_take) && (!dbl_on || (cur_phase == cfg.phase_sel));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         locked_q <= 1'b0;
         phase_q  <= 1'b0;
         pos_q    <= '0;
         err_q    <= 1'b0;
      end else begin
         locked_q <= locked_q || fp_take;
         phase_q  <= dbl_on && !cur_phase;
         pos_q    <= adv ? nxt_pos : cur_pos;
         err_q    <= fp_take && locked_q && (pos_q != '0);
      end
   end

   assign bit_pos   = cur_pos;
   assign locked_o  = locked_q;
   assign align_err = err_q;

   // R10
   resync_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !dbl_on) |-> (pos_q == POS_W'(1)));
endmodule

// File: rtl/mbx_deser.sv
module mbx_deser
   import mbx_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int POS_W  = 10,
   parameter int LINES  = 2,
   localparam int BIT_W = $clog2(BYTE_W),
   localparam int IDX_W = POS_W - BIT_W
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  mbx_cfg_t                     cfg,
   input  logic                         samp_en,
   input  logic [POS_W-1:0]             bit_pos,
   input  logic [LINES-1:0]             ser_in,
   output logic                         byte_done,
   output logic [IDX_W-1:0]             byte_idx,
   output logic [LINES-1:0][BYTE_W-1:0] par_out
);
   genvar g;
   generate
      for (g = 0; g < LINES; g++) begin : g_line
         logic [BYTE_W-1:0] sh_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sh_q <= '0;
            else if (samp_en) sh_q <= {sh_q[BYTE_W-2:0], ser_in[g]};
         end
         assign par_out[g] = {sh_q[BYTE_W-2:0], ser_in[g]};
      end
   endgenerate

   assign byte_done = samp_en && (bit_pos[BIT_W-1:0] == BIT_W'(BYTE_W - 1));
   assign byte_idx  = bit_pos[POS_W-1:BIT_W];

   // R5
   one_sample_per_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (samp_en && cfg.dbl) |=> !samp_en);
endmodule

// File: rtl/mbx_slot_out.sv
module mbx_slot_out
   import mbx_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int LANES  = 4,
   parameter int SLOTS  = 32,
   localparam int IDX_W  = $clog2(LANES * SLOTS),
   localparam int LANE_W = $clog2(LANES),
   localparam int SLOT_W = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  mbx_cfg_t          cfg,
   input  logic [IDX_W-1:0]  offset,
   input  logic              byte_done,
   input  logic [IDX_W-1:0]  byte_idx,
   input  logic [BYTE_W-1:0] byte_data,
   input  logic [BYTE_W-1:0] byte_sig,
   output logic              ts_valid,
   output logic [SLOT_W-1:0] ts_num,
   output logic [BYTE_W-1:0] ts_data,
   output logic [BYTE_W-1:0] ts_sig
);
   logic [IDX_W-1:0]  rel;
   logic              mine, subst;
   logic [SLOT_W-1:0] slot;

   always_comb begin
      rel   = byte_idx - offset;
      mine  = (rel[LANE_W-1:0] == '0);
      slot  = rel[IDX_W-1:LANE_W];
      subst = !cfg.ccs_en && !cfg.sig_src && (slot == SLOT_W'(SIG_SLOT));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ts_valid <= 1'b0;
         ts_num   <= '0;
         ts_data  <= '0;
         ts_sig   <= '0;
      end else begin
         ts_valid <= byte_done && mine;
         if (byte_done && mine) begin
            ts_num  <= slot;
            ts_data <= subst ? byte_sig : byte_data;
            ts_sig  <= byte_sig;
         end
      end
   end

   // R8
   sig_subst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ts_valid && ts_num == SLOT_W'(SIG_SLOT) && $past(!cfg.ccs_en && !cfg.sig_src))
      |-> (ts_data == ts_sig));
endmodule

// File: rtl/mbx_extract.sv
module mbx_extract
   import mbx_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter int LANES  = 4,
   parameter int SLOTS  = 32,
   parameter bit DBL_EN = 1'b1,
   localparam int IDX_W  = $clog2(LANES * SLOTS),
   localparam int SLOT_W = $clog2(SLOTS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_double_rate,
   input  logic              cfg_phase_sel,
   input  logic              cfg_fp_invert,
   input  logic [IDX_W-1:0]  cfg_slot_offset,
   input  logic              cfg_ccs_en,
   input  logic              cfg_sig_src,
   input  logic              bus_fp,
   input  logic              bus_data,
   input  logic              bus_sig,
   output logic              ts_valid,
   output logic [SLOT_W-1:0] ts_num,
   output logic [BYTE_W-1:0] ts_data,
   output logic [BYTE_W-1:0] ts_sig,
   output logic              align_err
);
   localparam int TOTAL_BITS = LANES * SLOTS * BYTE_W;
   localparam int POS_W      = $clog2(TOTAL_BITS);
   localparam int BIT_W      = $clog2(BYTE_W);

   generate
      if (LANES < 2 || (1 << $clog2(LANES)) != LANES) begin : g_bad_lanes
         $error("LANES must be a power of two, at least 2");
      end
      if (SLOTS <= SIG_SLOT || (1 << SLOT_W) != SLOTS) begin : g_bad_slots
         $error("SLOTS must be a power of two above the signaling slot");
      end
      if (BYTE_W < 2 || (1 << BIT_W) != BYTE_W) begin : g_bad_byte
         $error("BYTE_W must be a power of two, at least 2");
      end
   endgenerate

   mbx_cfg_t                  cfg;
   logic                      samp_en, locked, byte_done;
   logic [POS_W-1:0]          bit_pos;
   logic [IDX_W-1:0]          byte_idx;
   logic [1:0][BYTE_W-1:0]    par;

   assign cfg = '{dbl: cfg_double_rate, phase_sel: cfg_phase_sel, fp_inv: cfg_fp_invert,
                  ccs_en: cfg_ccs_en, sig_src: cfg_sig_src};

   mbx_timing #(.TOTAL_BITS(TOTAL_BITS), .POS_W(POS_W), .DBL_EN(DBL_EN)) u_timing (
      .clk(clk), .rst_n(rst_n), .cfg(cfg), .fp_in(bus_fp),
      .samp_en(samp_en), .bit_pos(bit_pos), .locked_o(locked), .align_err(align_err)
   );

   mbx_deser #(.BYTE_W(BYTE_W), .POS_W(POS_W), .LINES(2)) u_deser (
      .clk(clk), .rst_n(rst_n), .cfg(cfg), .samp_en(samp_en), .bit_pos(bit_pos),
      .ser_in({bus_sig, bus_data}), .byte_done(byte_done), .byte_idx(byte_idx),
      .par_out(par)
   );

   mbx_slot_out #(.BYTE_W(BYTE_W), .LANES(LANES), .SLOTS(SLOTS)) u_out (
      .clk(clk), .rst_n(rst_n), .cfg(cfg), .offset(cfg_slot_offset),
      .byte_done(byte_done), .byte_idx(byte_idx), .byte_data(par[0]), .byte_sig(par[1]),
      .ts_valid(ts_valid), .ts_num(ts_num), .ts_data(ts_data), .ts_sig(ts_sig)
   );

   // R11
   no_output_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !locked |=> !ts_valid);

   // R12
   valid_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ts_valid |=> !ts_valid);
endmodule

// File: tb/mbx_extract_tb_top.sv
module mbx_extract_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_double_rate = 0, cfg_phase_sel = 0, cfg_fp_invert = 0;
   logic [6:0] cfg_slot_offset = '0;
   logic       cfg_ccs_en = 1, cfg_sig_src = 0;
   logic       bus_fp = 0, bus_data = 0, bus_sig = 0;
   logic       ts_valid, align_err;
   logic [4:0] ts_num;
   logic [7:0] ts_data, ts_sig;

   always #2 clk = ~clk;

   mbx_extract dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_double_rate(cfg_double_rate),
      .cfg_phase_sel(cfg_phase_sel), .cfg_fp_invert(cfg_fp_invert),
      .cfg_slot_offset(cfg_slot_offset), .cfg_ccs_en(cfg_ccs_en), .cfg_sig_src(cfg_sig_src),
      .bus_fp(bus_fp), .bus_data(bus_data), .bus_sig(bus_sig),
      .ts_valid(ts_valid), .ts_num(ts_num), .ts_data(ts_data), .ts_sig(ts_sig),
      .align_err(align_err)
   );

   typedef struct { int slot; int data; int sig; } exp_t;
   exp_t  q[$];
   int    n_chk = 0, n_bad = 0, errs_seen = 0, errs_exp = 0;
   int    bidx = 0, salt = 0;
   bit    locked_b = 0;
   string cur_req = "";

   function automatic logic [7:0] dat_of(int k, int s);
      return 8'((k * 37 + s * 11 + 5) ^ (k >> 2));
   endfunction

   function automatic logic [7:0] sig_of(int k, int s);
      return 8'((k * 53 + s * 29 + 3) ^ 8'hA5);
   endfunction

   task automatic drive_cycle(input logic fp, input logic d, input logic sg);
      @(negedge clk);
      bus_fp   = cfg_fp_invert ? ~fp : fp;
      bus_data = d;
      bus_sig  = sg;
   endtask

   task automatic send_bytes(input int n, input bit fp_first, input bit glitch);
      for (int i = 0; i < n; i++) begin
         logic [7:0] d, sg;
         int rel;
         if (i == 0 && fp_first) begin
            if (locked_b && bidx != 0) errs_exp++;
            if (bidx != 0) salt++;
            bidx = 0;
            locked_b = 1;
         end
         d  = dat_of(bidx, salt);
         sg = sig_of(bidx, salt);
         if (locked_b) begin
            rel = (bidx - int'(cfg_slot_offset) + 128) % 128;
            if (rel % 4 == 0) begin
               exp_t e;
               e.slot = rel / 4;
               e.data = (!cfg_ccs_en && !cfg_sig_src && e.slot == 16) ? int'(sg) : int'(d);
               e.sig  = int'(sg);
               q.push_back(e);
            end
         end
         for (int b = 0; b < 8; b++) begin
            logic bd, bs, fpb, gl;
            bd  = d[7-b];
            bs  = sg[7-b];
            fpb = (i == 0 && b == 0 && fp_first);
            gl  = (i == 0 && b == 0 && glitch);
            if (!cfg_double_rate) drive_cycle(fpb, bd, bs);
            else begin
               for (int p = 0; p < 2; p++) begin
                  logic sel;
                  sel = (p == int'(cfg_phase_sel));
                  drive_cycle(fpb || (gl && p == 1), sel ? bd : ~bd, sel ? bs : ~bs);
               end
            end
         end
         bidx = (bidx + 1) % 128;
         if (bidx == 0) salt++;
      end
   endtask

   task automatic start_test(input string req, input bit dbl, input bit sel, input bit inv,
                             input int off, input bit ccs, input bit src);
      @(negedge clk);
      rst_n = 0;
      cur_req = req;
      cfg_double_rate = dbl; cfg_phase_sel = sel; cfg_fp_invert = inv;
      cfg_slot_offset = 7'(off); cfg_ccs_en = ccs; cfg_sig_src = src;
      bus_fp = inv; bus_data = 0; bus_sig = 0;
      q.delete();
      errs_seen = 0; errs_exp = 0; locked_b = 0; bidx = 0;
      repeat (3) @(negedge clk);
      n_chk++;
      if (ts_valid !== 1'b0 || align_err !== 1'b0) begin
         n_bad++;
         $display("FAIL R12 reset state: valid=%b err=%b expected 0 0", ts_valid, align_err);
      end
      rst_n = 1;
   endtask

   task automatic end_test();
      repeat (4) @(negedge clk);
      n_chk++;
      if (q.size() != 0) begin
         n_bad++;
         $display("FAIL R1 %s: %0d bytes not delivered, expected 0", cur_req, q.size());
      end
      n_chk++;
      if (errs_seen != errs_exp) begin
         n_bad++;
         $display("FAIL R10 R11 %s: align_err count %0d expected %0d", cur_req, errs_seen, errs_exp);
      end
   endtask

   // monitor / scoreboard
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (rst_n) begin
            if (align_err) errs_seen++;
            if (ts_valid) begin
               n_chk++;
               if (q.size() == 0) begin
                  n_bad++;
                  $display("FAIL R1 R11 %s: unexpected byte slot=%0d data=%h, expected none",
                           cur_req, ts_num, ts_data);
               end else begin
                  exp_t e;
                  e = q.pop_front();
                  if (int'(ts_num) != e.slot || int'(ts_data) != e.data || int'(ts_sig) != e.sig) begin
                     n_bad++;
                     $display("FAIL %s: slot=%0d data=%h sig=%h expected slot=%0d data=%h sig=%h",
                              cur_req, ts_num, ts_data, ts_sig, e.slot, e.data[7:0], e.sig[7:0]);
                  end
               end
            end
         end
      end
   end

   initial begin
      #(4 * 150000);
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      // R1 R2 R3 R4 R11 R12: single rate, offset 0, idle bus before first pulse
      start_test("R1 R2 R3 R4 R11", 0, 0, 0, 0, 1, 0);
      send_bytes(3, 0, 0);
      send_bytes(128, 1, 0);
      send_bytes(128, 1, 0);
      end_test();
      // R2 R8: offset 5 wraps slots, slot 16 replaced by signaling
      start_test("R2 R8", 0, 0, 0, 5, 0, 0);
      send_bytes(128, 1, 0);
      send_bytes(128, 1, 0);
      end_test();
      // R9: signaling source 1 keeps bus data in slot 16
      start_test("R9 src", 0, 0, 0, 2, 0, 1);
      send_bytes(128, 1, 0);
      end_test();
      // R9: common-channel enabled keeps bus data in slot 16
      start_test("R9 ccs", 0, 0, 0, 127, 1, 0);
      send_bytes(128, 1, 0);
      end_test();
      // R7: inverted frame pulse polarity
      start_test("R7", 0, 0, 1, 3, 0, 0);
      send_bytes(2, 0, 0);
      send_bytes(128, 1, 0);
      send_bytes(128, 1, 0);
      end_test();
      // R5: double rate, first cycle samples
      start_test("R5 phase0", 1, 0, 0, 1, 0, 0);
      send_bytes(128, 1, 0);
      send_bytes(128, 1, 0);
      end_test();
      // R5 R6: double rate, second cycle samples, pulse on second cycle ignored
      start_test("R5 R6 phase1", 1, 1, 0, 6, 1, 0);
      send_bytes(128, 1, 0);
      send_bytes(60, 0, 0);
      send_bytes(10, 0, 1);
      send_bytes(58, 0, 0);
      send_bytes(128, 1, 0);
      end_test();
      // R10: misaligned pulses in single rate
      start_test("R10 single", 0, 0, 0, 0, 1, 0);
      send_bytes(128, 1, 0);
      send_bytes(40, 0, 0);
      send_bytes(100, 1, 0);
      send_bytes(50, 1, 0);
      end_test();
      // R10: misaligned pulse in double rate
      start_test("R10 double", 1, 1, 0, 9, 0, 0);
      send_bytes(50, 1, 0);
      send_bytes(128, 1, 0);
      send_bytes(20, 0, 0);
      end_test();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule